// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that sets an absolute deadline against a free-running 64-bit system counter. It does not count down. The deadline is held in a compare register. Each refresh reloads that register with the current counter value plus a programmed offset. If the counter reaches the deadline, the block enters its first stage: it raises an interrupt and sets a new deadline one offset further on. If no refresh arrives before that second deadline, it enters the second stage and drives a reset request pulse of fixed length. The time from the last refresh to the reset is therefore twice the offset.

Software reaches the block through two small register frames. The refresh frame has one register. Any write to it restarts the timer. The control frame holds:
- a control/status word, with enable, first-stage flag and second-stage flag;
- the offset;
- the 64-bit compare value;
- an identification word that reports the offset-width version.

The second-stage flag and the reset pulse counter are held in a separate power-on reset domain. Software can therefore read the flag after the system reset that the pulse caused.

Top module: `gwdt_two_stage`

## Requirements
- R1: After reset the control word (0x000) reads 0, the interrupt and reset outputs are low, and bits [19:16] of the identification word (0xFCC in either frame) hold the VERSION parameter.
- R2: In the control word, bit 0 is enable, bit 1 is the first-stage flag and bit 2 is the second-stage flag. A write to 0x000 loads enable from data bit 0 and also performs a refresh.
- R3: A refresh loads compare = system counter + offset at the write edge and clears both stage flags. A write of any data to refresh-frame address 0x000 is a refresh.
- R4: A write to the offset (0x008, and 0x00C when VERSION is 1) is a refresh only while enable is set. The refresh uses the newly written offset.
- R5: While enabled, with the first-stage flag clear and counter >= compare at an edge, the first-stage flag is set and compare is reloaded to counter + offset. `irq_ws0` is high exactly while that flag is set.
- R6: While enabled, with the first-stage flag set and counter >= compare, the second-stage flag is set. `rst_req` is then high for exactly RST_CYCLES cycles, starting with the cycle after that edge.
- R7: While enable is clear, neither stage flag advances, however far the counter is past compare.
- R8: The second-stage flag is not cleared by `rst_n`. It is cleared only by `por_n` or by a refresh.
- R9: With VERSION 1 the offset is 48 bits. Its upper 16 bits are at 0x00C in data bits [15:0], and data bits [31:16] of 0x00C read as zero and ignore writes.
- R10: The compare value can be read and written at 0x010 (low word) and 0x014 (high word). Writing it is not a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| por_n | input | 1 | Active-low power-on reset for the second-stage flag and pulse |
| sys_cnt | input | 64 | Free-running system counter |
| rf_wr | input | 1 | Refresh-frame write strobe |
| rf_addr | input | 12 | Refresh-frame byte address |
| rf_wdata | input | 32 | Refresh-frame write data (value ignored) |
| rf_rdata | output | 32 | Refresh-frame read data (combinational) |
| cf_wr | input | 1 | Control-frame write strobe |
| cf_addr | input | 12 | Control-frame byte address |
| cf_wdata | input | 32 | Control-frame write data |
| cf_rdata | output | 32 | Control-frame read data (combinational) |
| irq_ws0 | output | 1 | First-stage interrupt, level high |
| rst_req | output | 1 | Second-stage reset request pulse |

## Verification
Register reads are combinational, so the bench samples them in the same cycle it sets the address. A write takes effect at the one rising edge it spans. Counting edges from that write, the first-stage flag and `irq_ws0` rise after exactly offset edges, and the second-stage flag and `rst_req` rise after twice the offset. The pulse then stays high for RST_CYCLES samples. The bench drives inputs one time unit after the falling edge and records the counter value at the write edge. It then predicts each flag, output and compare readback from that edge count, and compares it at the following falling edge. That includes random offsets with random waits that fall on either side of each boundary.

// File: rtl/gwdt_two_stage.sv
module gwdt_two_stage #(
  parameter int          VERSION    = 1,
  parameter int          RST_CYCLES = 8,
  parameter logic [15:0] ID_LO      = 16'h5A31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic [63:0] sys_cnt,
  input  logic        rf_wr,
  input  logic [11:0] rf_addr,
  input  logic [31:0] rf_wdata,
  output logic [31:0] rf_rdata,
  input  logic        cf_wr,
  input  logic [11:0] cf_addr,
  input  logic [31:0] cf_wdata,
  output logic [31:0] cf_rdata,
  output logic        irq_ws0,
  output logic        rst_req
);

  localparam int OFF_W = (VERSION == 0) ? 32 : 48;
  localparam int PW    = $clog2(RST_CYCLES + 1);
  localparam logic [11:0] A_CTL = 12'h000, A_OLO = 12'h008, A_OHI = 12'h00C,
                          A_CLO = 12'h010, A_CHI = 12'h014, A_ID = 12'hFCC;

  logic             en_q, ws0_q, ws1_q;
  logic [OFF_W-1:0] off_q, off_nxt;
  logic [47:0]      off48, off48_nxt;
  logic [63:0]      cmp_q;
  logic [PW-1:0]    pulse_q;
  logic [31:0]      id_word;

  logic wr_ctl, wr_olo, wr_ohi, wr_clo, wr_chi, refresh, expire, hit0, hit1;
  logic unused_bits;

  assign unused_bits = ^{rf_wdata, cf_wdata[31:16]};
  assign id_word = {12'h000, 4'(VERSION), ID_LO};

  assign wr_ctl = cf_wr && (cf_addr == A_CTL);
  assign wr_olo = cf_wr && (cf_addr == A_OLO);
  assign wr_ohi = cf_wr && (cf_addr == A_OHI) && (VERSION != 0);
  assign wr_clo = cf_wr && (cf_addr == A_CLO);
  assign wr_chi = cf_wr && (cf_addr == A_CHI);

  assign refresh = (rf_wr && (rf_addr == A_CTL)) || wr_ctl || ((wr_olo || wr_ohi) && en_q);
  assign expire  = en_q && (sys_cnt >= cmp_q) && !refresh && !wr_clo && !wr_chi;
  assign hit0    = expire && !ws0_q;
  assign hit1    = expire && ws0_q && !ws1_q;

  assign off48 = 48'(off_q);
  always_comb begin
    off48_nxt = off48;
    if (wr_olo) off48_nxt[31:0]  = cf_wdata;
    if (wr_ohi) off48_nxt[47:32] = cf_wdata[15:0];
    off_nxt = OFF_W'(off48_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ws0_q <= 1'b0;
      off_q <= '0;
      cmp_q <= '0;
    end else begin
      off_q <= off_nxt;
      if (wr_ctl) en_q <= cf_wdata[0];
      if (refresh) begin
        cmp_q <= sys_cnt + 64'(off_nxt);
        ws0_q <= 1'b0;
      end else if (wr_clo || wr_chi) begin
        if (wr_clo) cmp_q[31:0]  <= cf_wdata;
        if (wr_chi) cmp_q[63:32] <= cf_wdata;
      end else if (hit0) begin
        cmp_q <= sys_cnt + 64'(off_q);
        ws0_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ws1_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (refresh)   ws1_q <= 1'b0;
      else if (hit1) ws1_q <= 1'b1;
      if (hit1)                  pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)    pulse_q <= pulse_q - 1'b1;
    end
  end

  assign irq_ws0 = ws0_q;
  assign rst_req = (pulse_q != '0);

  always_comb begin
    unique case (cf_addr)
      A_CTL:   cf_rdata = {29'd0, ws1_q, ws0_q, en_q};
      A_OLO:   cf_rdata = off48[31:0];
      A_OHI:   cf_rdata = (VERSION != 0) ? {16'h0000, off48[47:32]} : 32'd0;
      A_CLO:   cf_rdata = cmp_q[31:0];
      A_CHI:   cf_rdata = cmp_q[63:32];
      A_ID:    cf_rdata = id_word;
      default: cf_rdata = 32'd0;
    endcase
  end

  assign rf_rdata = (rf_addr == A_ID) ? id_word : 32'd0;

  p_ws0_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws0_q) |-> $past(en_q));
  p_ws1_after_ws0_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(ws1_q) |-> ($past(ws0_q) && rst_req));
  p_refresh_clears_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    refresh |=> (!ws0_q && !ws1_q));
  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!en_q && !refresh) |=> ($stable(ws0_q) && $stable(ws1_q)));
  p_ohi_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_addr == A_OHI) |-> (cf_rdata[31:16] == 16'h0000));

endmodule

// File: tb/gwdt_two_stage_tb.sv
`timescale 1ns/100ps
module gwdt_two_stage_tb;
  localparam int RST = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic [63:0] cnt = 64'h0000_0001_FFFF_FF00;
  logic        rf_wr = 1'b0, cf_wr = 1'b0;
  logic [11:0] rf_addr = '0, cf_addr = '0;
  logic [31:0] rf_wdata = '0, cf_wdata = '0;
  logic [31:0] rf_rdata, cf_rdata;
  logic        irq_ws0, rst_req;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] cnt_w;

  always #2.5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 64'd1;

  gwdt_two_stage #(.VERSION(1), .RST_CYCLES(RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .sys_cnt(cnt),
    .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata), .cf_rdata(cf_rdata),
    .irq_ws0(irq_ws0), .rst_req(rst_req));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic cf_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    cf_addr = a; cf_wdata = d; cf_wr = 1'b1; cnt_w = cnt;
    @(negedge clk); #1;
    cf_wr = 1'b0;
  endtask

  task automatic rf_write(input logic [31:0] d);
    @(negedge clk); #1;
    rf_addr = 12'h000; rf_wdata = d; rf_wr = 1'b1; cnt_w = cnt;
    @(negedge clk); #1;
    rf_wr = 1'b0;
  endtask

  task automatic cf_read(input logic [11:0] a, output logic [31:0] d);
    cf_addr = a; #0.5; d = cf_rdata;
  endtask

  function automatic logic [31:0] status_exp(input logic en, input logic s0, input logic s1);
    return {29'd0, s1, s0, en};
  endfunction

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo, hi;
    int hi_cnt;
    void'($urandom(32'd1234));
    edges(3);
    rst_n = 1'b1; por_n = 1'b1;
    edges(1);

    cf_read(12'h000, d); chk("R1 status", d, 0);
    chk("R1 irq", irq_ws0, 0); chk("R1 rst", rst_req, 0);
    cf_read(12'hFCC, d); chk("R1 cf id version", d[19:16], 1);
    rf_addr = 12'hFCC; #0.5; chk("R1 rf id version", rf_rdata[19:16], 1);

    edges(10);
    cf_read(12'h000, d); chk("R7 disabled no advance", d, 0);

    cf_write(12'h010, 32'h1234_5678);
    cf_write(12'h014, 32'h0000_00AB);
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R10 compare readback", {hi, lo}, 64'h0000_00AB_1234_5678);
    cf_read(12'h000, d); chk("R10 compare write no refresh", d, 0);

    cf_write(12'h008, 32'd5);
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R4 offset write disabled keeps compare", {hi, lo}, 64'h0000_00AB_1234_5678);
    cf_read(12'h008, d); chk("R4 offset readback", d, 5);

    cf_write(12'h00C, 32'hFFFF_0002);
    cf_read(12'h00C, d); chk("R9 offset high word", d, 32'h0000_0002);
    cf_write(12'h00C, 32'h0);

    cf_write(12'h000, 32'h1);
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R3 refresh loads compare", {hi, lo}, cnt_w + 64'd5);
    cf_read(12'h000, d); chk("R2 enable bit", d, status_exp(1, 0, 0));
    edges(4); chk("R5 irq before first expiry", irq_ws0, 0);
    edges(1); chk("R5 irq at first expiry", irq_ws0, 1);
    cf_read(12'h000, d); chk("R2 stage0 bit", d, status_exp(1, 1, 0));
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R5 compare reload", {hi, lo}, cnt_w + 64'd10);
    edges(4);
    cf_read(12'h000, d); chk("R6 no stage1 yet", d[2], 0);
    chk("R6 no pulse yet", rst_req, 0);
    edges(1);
    cf_read(12'h000, d); chk("R6 stage1 bit", d, status_exp(1, 1, 1));
    hi_cnt = 0;
    for (int i = 0; i < RST + 3; i++) begin
      if (rst_req) hi_cnt++;
      edges(1);
    end
    chk("R6 pulse length", hi_cnt, RST);

    rst_n = 1'b0; edges(2); rst_n = 1'b1; edges(1);
    cf_read(12'h000, d); chk("R8 stage1 survives rst_n", d, status_exp(0, 0, 1));
    por_n = 1'b0; edges(1); por_n = 1'b1; edges(1);
    cf_read(12'h000, d); chk("R8 por clears stage1", d, 0);

    cf_write(12'h008, 32'd5);
    cf_write(12'h000, 32'h1);
    edges(3);
    cf_write(12'h008, 32'd20);
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R4 offset write enabled refreshes", {hi, lo}, cnt_w + 64'd20);
    edges(20); chk("R5 irq after 20", irq_ws0, 1);
    rf_write(32'hDEAD_BEEF);
    cf_read(12'h000, d); chk("R3 refresh frame clears stage0", d, status_exp(1, 0, 0));
    chk("R3 irq cleared", irq_ws0, 0);
    cf_read(12'h010, lo); cf_read(12'h014, hi);
    chk("R3 refresh frame reload", {hi, lo}, cnt_w + 64'd20);

    cf_write(12'h000, 32'h0);
    edges(50);
    cf_read(12'h000, d); chk("R7 stopped", d, 0);
    chk("R7 irq stays low", irq_ws0, 0);

    cf_write(12'h000, 32'h1);
    for (int it = 0; it < 24; it++) begin
      int off, w, rest;
      off = $urandom_range(2, 30);
      w = $urandom_range(0, 2 * off + RST + 2);
      cf_write(12'h008, off);
      edges(w);
      cf_read(12'h000, d);
      chk("R5 random irq", irq_ws0, (w >= off));
      chk("R6 random stage1", d[2], (w >= 2 * off));
      chk("R6 random pulse", rst_req, (w >= 2 * off) && (w < 2 * off + RST));
      rest = 2 * off + RST + 1 - w;
      if (rest > 0) edges(rest);
      rf_write($urandom);
      cf_read(12'h000, d); chk("R3 random refresh", d, status_exp(1, 0, 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule